// File: doc/BRIEF.md
# Microstep Phase Sequencer

This block drives the low-voltage side of a four-phase unipolar stepper. It keeps one position counter with 64 steps per electrical cycle. It moves that counter on filtered transitions of a slow step clock, and from the position it produces four phase-enable lines and a 7-bit current-ratio code for each winding axis. The ratio codes are percent values, 0 to 100. A downstream chopper uses them to set the winding current. A two-bit monitor reports which quarter of the electrical cycle the position is in.

A three-bit mode select picks one of five excitation resolutions. It also picks whether the step clock advances on rising edges only or on both edges. Changing the mode keeps the current position. All inputs are asynchronous to the system clock. The step clock passes through a synchronizer and a majority vote, and every control input is re-timed by a two-stage synchronizer.

Top module: `msq_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, every phase line and both ratio codes go to 0, `mon` goes to 00 and the position returns to 0.
- R2: The step clock is voted over three synchronized samples, so a level that lasts one system cycle produces no step. A level that lasts two or more cycles counts as a transition. The outputs reflect a transition on the 6th rising clock edge after the input changed.
- R3: With `mode_sel[0]`=1 only rising step-clock transitions move the position. With `mode_sel[0]`=0 both rising and falling transitions move it.
- R4: The stride per step depends on `mode_sel` = {m1,m2,m3}, written as binary value→stride: 000→8, 010→2, 100→4, 110→1, 001→16, 011→4, 101→8, 111→2. The position wraps modulo 64, and it does not change without a step, return or clear.
- R5: When `dir_fwd`=1 the stride is added to the position; when `dir_fwd`=0 it is subtracted.
- R6: Let the position be p, k = p mod 16 and Q = p/16. The A-axis index is k when Q is even and 16-k when Q is odd, and the B-axis index is 16 minus the A-axis index. The level for index 0..16 is 100,100,100,96,92,87,83,77,71,63,55,47,40,30,20,10,0. Each code never exceeds 100.
- R7: `ph_a` is high when the A level is nonzero and Q is 0 or 3. `ph_a_n` is high when the A level is nonzero and Q is 1 or 2. `ph_b` is high when the B level is nonzero and Q is 0 or 1. `ph_b_n` is high when the B level is nonzero and Q is 2 or 3. Opposite lines of one axis are never high together.
- R8: In mode 001 both ratio codes are 100 at every position, and the phase lines follow the quarter rules of R7.
- R9: `mon` equals Q: 00 for the A quarter, 01 for B, 10 for A-bar and 11 for B-bar. It is updated whether or not the outputs are enabled.
- R10: While `en_n` is high, every phase line and both ratio codes are 0 (3 cycles after `en_n` changes) and the position is kept.
- R11: A high `home` or a low `clr_n` forces the position to 0 (on the 3rd clock edge after the input changes) with priority over a step.
- R12: A change of `mode_sel` keeps the position. The next step adds the new mode's stride to the old position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_clk | input | 1 | Asynchronous step clock, idles high |
| dir_fwd | input | 1 | 1 = forward, 0 = reverse |
| mode_sel | input | 3 | Excitation select {m1,m2,m3}; bit 0 picks rising-only stepping |
| home | input | 1 | Active-high return to origin |
| clr_n | input | 1 | Active-low sequencer clear to origin |
| en_n | input | 1 | Active-low output enable |
| ph_a | output | 1 | A phase active |
| ph_a_n | output | 1 | A-bar phase active |
| ph_b | output | 1 | B phase active |
| ph_b_n | output | 1 | B-bar phase active |
| ratio_a | output | 7 | A-axis current ratio, percent |
| ratio_b | output | 7 | B-axis current ratio, percent |
| mon | output | 2 | Active quarter monitor |

## Verification
A step-clock change reaches the outputs on the 6th rising edge: two synchronizer stages, two voter samples to form a majority, the position register, then the output register. Enable and mode changes reach the outputs on the 3rd edge. Return and clear reach the position on the 3rd edge and the outputs on the 4th. The reference model keeps a queue of sampled inputs and reads each decision from the entry that is the matching number of edges old. The model updates at the rising edge, and the outputs are compared on every falling edge, half a cycle after they settle. The directed checks wait well past these latencies, except for one check that confirms the output is still the old value after 5 edges and the new value after 6.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int POS_W    = 6;
    localparam int LVL_W    = 7;
    localparam int QTR_LEN  = 2 ** (POS_W - 2);
    localparam int MODE_W   = 3;
    localparam int MON_W    = 2;
    localparam int IDX_W    = POS_W - 1;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [IDX_W-1:0] idx_t;

    localparam lvl_t LVL_FULL = lvl_t'(100);

    typedef enum logic [2:0] {
        EXC_FULL2,
        EXC_HALF,
        EXC_QUARTER,
        EXC_EIGHTH,
        EXC_SIXTEENTH
    } exc_e;

    typedef struct packed {
        logic a;
        logic a_n;
        logic b;
        logic b_n;
    } phase_t;

    typedef struct packed {
        phase_t           ph;
        lvl_t             lvl_a;
        lvl_t             lvl_b;
        logic [MON_W-1:0] mon;
    } drive_t;

    typedef struct packed {
        logic              fwd;
        logic [MODE_W-1:0] mode;
        logic              home;
        logic              clr_n;
        logic              en_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{fwd: 1'b0, mode: '0, home: 1'b0,
                                    clr_n: 1'b1, en_n: 1'b1};

    function automatic exc_e decode_mode(input logic [MODE_W-1:0] m);
        exc_e e;
        case (m)
            3'b000:  e = EXC_HALF;
            3'b010:  e = EXC_EIGHTH;
            3'b100:  e = EXC_QUARTER;
            3'b110:  e = EXC_SIXTEENTH;
            3'b001:  e = EXC_FULL2;
            3'b011:  e = EXC_QUARTER;
            3'b101:  e = EXC_HALF;
            default: e = EXC_EIGHTH;
        endcase
        return e;
    endfunction

    function automatic pos_t stride_of(input exc_e e);
        pos_t s;
        case (e)
            EXC_FULL2:   s = pos_t'(QTR_LEN);
            EXC_HALF:    s = pos_t'(QTR_LEN / 2);
            EXC_QUARTER: s = pos_t'(QTR_LEN / 4);
            EXC_EIGHTH:  s = pos_t'(QTR_LEN / 8);
            default:     s = pos_t'(1);
        endcase
        return s;
    endfunction

    function automatic lvl_t eighth_level(input logic [3:0] e);
        lvl_t v;
        case (e)
            4'd0:    v = lvl_t'(100);
            4'd1:    v = lvl_t'(100);
            4'd2:    v = lvl_t'(92);
            4'd3:    v = lvl_t'(83);
            4'd4:    v = lvl_t'(71);
            4'd5:    v = lvl_t'(55);
            4'd6:    v = lvl_t'(40);
            4'd7:    v = lvl_t'(20);
            default: v = lvl_t'(0);
        endcase
        return v;
    endfunction

    function automatic lvl_t fine_level(input idx_t k);
        logic [LVL_W:0] sum;
        logic [3:0]     lo;
        lo = k[IDX_W-1:1];
        sum = {1'b0, eighth_level(lo)} + {1'b0, eighth_level(lo + 4'd1)};
        if (!k[0]) return eighth_level(lo);
        return lvl_t'(sum >> 1);
    endfunction

endpackage

// File: rtl/msq_sync.sv
module msq_sync #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/msq_step_filter.sv
module msq_step_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic step_in,
    output logic rise,
    output logic fall
);

    localparam int CNT_W = $clog2(TAPS + 1);

    logic synced;
    logic vote;
    logic level_q;

    msq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (step_in),
        .q   (synced)
    );

    if (TAPS == 1) begin : g_direct
        assign vote = synced;
    end else begin : g_vote
        logic [TAPS-1:0]  win;
        logic [CNT_W-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst) win <= '1;
            else     win <= {win[TAPS-2:0], synced};
        end

        always_comb begin
            cnt = '0;
            for (int i = 0; i < TAPS; i++) cnt = cnt + CNT_W'(win[i]);
        end

        assign vote = (cnt > CNT_W'(TAPS / 2));
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= vote;
    end

    assign rise = vote & ~level_q;
    assign fall = ~vote & level_q;

endmodule

// File: rtl/msq_position.sv
module msq_position
    import msq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic fwd,
    input  pos_t stride,
    input  logic origin,
    output pos_t pos
);

    pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst)            pos_q <= '0;
        else if (origin)    pos_q <= '0;
        else if (step) begin
            if (fwd) pos_q <= pos_q + stride;
            else     pos_q <= pos_q - stride;
        end
    end

    assign pos = pos_q;

endmodule

// File: rtl/msq_drive.sv
module msq_drive
    import msq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pos_t   pos,
    input  exc_e   exc,
    input  logic   en,
    output drive_t drv
);

    logic [MON_W-1:0]   qtr;
    logic [POS_W-3:0]   sub;
    idx_t               idx_a;
    idx_t               idx_b;
    lvl_t               mag_a;
    lvl_t               mag_b;
    logic               a_pos;
    logic               b_pos;
    drive_t             nxt;
    drive_t             drv_q;

    always_comb begin
        qtr   = pos[POS_W-1:POS_W-2];
        sub   = pos[POS_W-3:0];
        idx_a = qtr[0] ? (idx_t'(QTR_LEN) - idx_t'(sub)) : idx_t'(sub);
        idx_b = idx_t'(QTR_LEN) - idx_a;

        if (exc == EXC_FULL2) begin
            mag_a = LVL_FULL;
            mag_b = LVL_FULL;
        end else begin
            mag_a = fine_level(idx_a);
            mag_b = fine_level(idx_b);
        end

        a_pos = (qtr == 2'd0) || (qtr == 2'd3);
        b_pos = ~qtr[1];

        nxt.mon      = qtr;
        nxt.ph.a     = en && (mag_a != '0) &&  a_pos;
        nxt.ph.a_n   = en && (mag_a != '0) && !a_pos;
        nxt.ph.b     = en && (mag_b != '0) &&  b_pos;
        nxt.ph.b_n   = en && (mag_b != '0) && !b_pos;
        nxt.lvl_a    = en ? mag_a : '0;
        nxt.lvl_b    = en ? mag_b : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) drv_q <= '0;
        else     drv_q <= nxt;
    end

    assign drv = drv_q;

endmodule

// File: rtl/msq_sequencer.sv
module msq_sequencer
    import msq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_clk,
    input  logic              dir_fwd,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              home,
    input  logic              clr_n,
    input  logic              en_n,
    output logic              ph_a,
    output logic              ph_a_n,
    output logic              ph_b,
    output logic              ph_b_n,
    output logic [LVL_W-1:0]  ratio_a,
    output logic [LVL_W-1:0]  ratio_b,
    output logic [MON_W-1:0]  mon
);

    ctrl_t  ctrl_raw;
    ctrl_t  ctrl_s;
    logic   step_rise;
    logic   step_fall;
    logic   both_edges;
    logic   step_fire;
    logic   origin;
    exc_e   exc;
    pos_t   stride;
    pos_t   pos;
    drive_t drv;

    assign ctrl_raw = '{fwd: dir_fwd, mode: mode_sel, home: home,
                        clr_n: clr_n, en_n: en_n};

    msq_sync #(.WIDTH($bits(ctrl_t)), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctrl_raw),
        .q   (ctrl_s)
    );

    msq_step_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .step_in (step_clk),
        .rise    (step_rise),
        .fall    (step_fall)
    );

    assign exc        = decode_mode(ctrl_s.mode);
    assign stride     = stride_of(exc);
    assign both_edges = ~ctrl_s.mode[0];
    assign step_fire  = step_rise | (step_fall & both_edges);
    assign origin     = ctrl_s.home | ~ctrl_s.clr_n;

    msq_position u_pos (
        .clk    (clk),
        .rst    (rst),
        .step   (step_fire),
        .fwd    (ctrl_s.fwd),
        .stride (stride),
        .origin (origin),
        .pos    (pos)
    );

    msq_drive u_drive (
        .clk (clk),
        .rst (rst),
        .pos (pos),
        .exc (exc),
        .en  (~ctrl_s.en_n),
        .drv (drv)
    );

    assign ph_a    = drv.ph.a;
    assign ph_a_n  = drv.ph.a_n;
    assign ph_b    = drv.ph.b;
    assign ph_b_n  = drv.ph.b_n;
    assign ratio_a = drv.lvl_a;
    assign ratio_b = drv.lvl_b;
    assign mon     = drv.mon;

endmodule

// File: rtl/msq_checker.sv
module msq_checker
    import msq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en_s_n,
    input logic              home_s,
    input logic              clr_s_n,
    input logic [MODE_W-1:0] mode_s,
    input logic              step_fire,
    input pos_t              pos,
    input logic              ph_a,
    input logic              ph_a_n,
    input logic              ph_b,
    input logic              ph_b_n,
    input lvl_t              ratio_a,
    input lvl_t              ratio_b,
    input logic [MON_W-1:0]  mon
);

    assert_axis_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(ph_a && ph_a_n) && !(ph_b && ph_b_n));

    assert_ratio_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (ratio_a <= LVL_FULL) && (ratio_b <= LVL_FULL));

    assert_cutoff_R10: assert property (@(posedge clk) disable iff (rst)
        en_s_n |=> (!ph_a && !ph_a_n && !ph_b && !ph_b_n && ratio_a == '0 && ratio_b == '0));

    assert_origin_R11: assert property (@(posedge clk) disable iff (rst)
        (home_s || !clr_s_n) |=> (pos == '0));

    assert_pos_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!step_fire && !home_s && clr_s_n) |=> $stable(pos));

    assert_two_phase_full_R8: assert property (@(posedge clk) disable iff (rst)
        (!en_s_n && mode_s == 3'b001) |=> (ratio_a == LVL_FULL && ratio_b == LVL_FULL));

    assert_monitor_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (mon == $past(pos[POS_W-1:POS_W-2])));

endmodule

bind msq_sequencer msq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_s_n    (ctrl_s.en_n),
    .home_s    (ctrl_s.home),
    .clr_s_n   (ctrl_s.clr_n),
    .mode_s    (ctrl_s.mode),
    .step_fire (step_fire),
    .pos       (pos),
    .ph_a      (ph_a),
    .ph_a_n    (ph_a_n),
    .ph_b      (ph_b),
    .ph_b_n    (ph_b_n),
    .ratio_a   (ratio_a),
    .ratio_b   (ratio_b),
    .mon       (mon)
);

// File: tb/sim_msq_sequencer.sv
module sim_msq_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_clk = 1'b1;
    logic       dir_fwd = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       home = 1'b0;
    logic       clr_n = 1'b1;
    logic       en_n = 1'b1;
    logic       ph_a, ph_a_n, ph_b, ph_b_n;
    logic [6:0] ratio_a, ratio_b;
    logic [1:0] mon;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    msq_sequencer u0 (
        .clk(clk), .rst(rst), .step_clk(step_clk), .dir_fwd(dir_fwd),
        .mode_sel(mode_sel), .home(home), .clr_n(clr_n), .en_n(en_n),
        .ph_a(ph_a), .ph_a_n(ph_a_n), .ph_b(ph_b), .ph_b_n(ph_b_n),
        .ratio_a(ratio_a), .ratio_b(ratio_b), .mon(mon)
    );

    // reference tables from the requirements
    int lvl_tab [0:16] = '{100,100,100,96,92,87,83,77,71,63,55,47,40,30,20,10,0};
    int stride_tab [0:7] = '{8,16,2,4,4,8,1,2};

    typedef struct {
        bit       sc;
        bit       fwd;
        bit [2:0] mode;
        bit       home;
        bit       clr_n;
        bit       en_n;
    } smp_t;

    smp_t hist[$];
    int   mpos = 0;
    bit   mlvl = 1;
    int   e_ra = 0, e_rb = 0, e_mon = 0;
    bit   e_pa = 0, e_pan = 0, e_pb = 0, e_pbn = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // behavioural reference model: inputs delayed through a queue
    always @(posedge clk) begin : model
        smp_t cur;
        smp_t idle;
        int q, k, ia, ma, mb, votes, st;
        bit en, full, apos, bpos, maj, fire;
        cur  = '{step_clk, dir_fwd, mode_sel, home, clr_n, en_n};
        idle = '{1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1};
        if (rst) begin
            hist.delete();
            for (int i = 0; i < 6; i++) hist.push_back(idle);
            mpos = 0; mlvl = 1;
            e_ra = 0; e_rb = 0; e_mon = 0;
            e_pa = 0; e_pan = 0; e_pb = 0; e_pbn = 0;
        end else begin
            hist.push_front(cur);
            en   = !hist[2].en_n;
            full = (hist[2].mode == 3'b001);
            q  = mpos / 16;
            k  = mpos % 16;
            ia = (q % 2 == 0) ? k : 16 - k;
            ma = full ? 100 : lvl_tab[ia];
            mb = full ? 100 : lvl_tab[16 - ia];
            apos = (q == 0) || (q == 3);
            bpos = (q < 2);
            e_ra  = en ? ma : 0;
            e_rb  = en ? mb : 0;
            e_pa  = en && ma != 0 && apos;
            e_pan = en && ma != 0 && !apos;
            e_pb  = en && mb != 0 && bpos;
            e_pbn = en && mb != 0 && !bpos;
            e_mon = q;
            votes = int'(hist[3].sc) + int'(hist[4].sc) + int'(hist[5].sc);
            maj = (votes >= 2);
            fire = 0;
            if (maj != mlvl) begin
                fire = maj || (hist[2].mode[0] == 1'b0);
                mlvl = maj;
            end
            st = stride_tab[hist[2].mode];
            if (!hist[2].clr_n || hist[2].home) mpos = 0;
            else if (fire) mpos = (mpos + (hist[2].fwd ? st : 64 - st)) % 64;
            void'(hist.pop_back());
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk(ratio_a == e_ra, "R6", "ratio_a", ratio_a, e_ra);
            chk(ratio_b == e_rb, "R6", "ratio_b", ratio_b, e_rb);
            chk({ph_a, ph_a_n, ph_b, ph_b_n} == {e_pa, e_pan, e_pb, e_pbn}, "R7", "phases",
                {ph_a, ph_a_n, ph_b, ph_b_n}, {e_pa, e_pan, e_pb, e_pbn});
            chk(mon == e_mon, "R9", "mon", mon, e_mon);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_step(input int hold);
        @(negedge clk);
        step_clk = ~step_clk;
        wait_cyc(hold);
    endtask

    initial begin
        #(8 * 150000);
        chk(0, "R2", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        wait_cyc(4);
        // R1 reset state
        chk(ratio_a == 0 && ratio_b == 0, "R1", "ratios in reset", ratio_a, 0);
        chk({ph_a, ph_a_n, ph_b, ph_b_n} == 4'b0, "R1", "phases in reset", {ph_a, ph_a_n, ph_b, ph_b_n}, 0);
        chk(mon == 0, "R1", "mon in reset", mon, 0);

        rst = 0; en_n = 0; mode_sel = 3'b101; dir_fwd = 1;
        wait_cyc(8);
        chk(ratio_a == 100 && ratio_b == 0 && ph_a, "R1", "origin levels", ratio_a, 100);

        // R3: falling edge ignored in rising-only mode
        toggle_step(12);
        chk(ratio_a == 100, "R3", "falling ignored", ratio_a, 100);
        toggle_step(12);
        chk(ratio_a == 71 && ratio_b == 71, "R4", "1-2 stride to 8", ratio_b, 71);
        chk(ph_a && ph_b, "R7", "both positive phases at 8", {ph_a, ph_b}, 3);

        // R3: both-edge mode, stride 4
        mode_sel = 3'b100;
        wait_cyc(6);
        toggle_step(12);
        chk(ratio_a == 40 && ratio_b == 92, "R3", "falling steps in both-edge", ratio_a, 40);
        toggle_step(12);
        chk(ratio_a == 0 && ratio_b == 100 && ph_b && !ph_a && !ph_a_n, "R7", "B quarter", ratio_b, 100);
        chk(mon == 1, "R9", "mon B quarter", mon, 1);

        // R5 reverse, finest stride
        dir_fwd = 0; mode_sel = 3'b110;
        wait_cyc(6);
        toggle_step(12);
        chk(ratio_a == 10 && ratio_b == 100 && mon == 0, "R5", "reverse to 15", ratio_a, 10);

        // R2 latency: old after 5 edges, new after 6
        @(negedge clk);
        step_clk = ~step_clk;
        wait_cyc(5);
        chk(ratio_a == 10, "R2", "not yet after 5 edges", ratio_a, 10);
        wait_cyc(1);
        chk(ratio_a == 20, "R2", "updated after 6 edges", ratio_a, 20);
        wait_cyc(6);

        // R2 glitch rejection
        @(negedge clk); step_clk = 0;
        @(negedge clk); step_clk = 1;
        wait_cyc(12);
        chk(ratio_a == 20 && ratio_b == 100, "R2", "one-cycle glitch ignored", ratio_a, 20);

        // R8 two-phase
        mode_sel = 3'b001;
        wait_cyc(8);
        chk(ratio_a == 100 && ratio_b == 100 && ph_a && ph_b, "R8", "two-phase full", ratio_a, 100);

        // R10 enable cutoff and position kept
        en_n = 1;
        wait_cyc(8);
        chk({ph_a, ph_a_n, ph_b, ph_b_n} == 0 && ratio_a == 0 && ratio_b == 0, "R10", "cutoff",
            ratio_b, 0);
        en_n = 0; mode_sel = 3'b110;
        wait_cyc(8);
        chk(ratio_a == 20, "R10", "position kept", ratio_a, 20);

        // R12 phase hold across mode change: 14 + 8 = 22
        mode_sel = 3'b101; dir_fwd = 1;
        wait_cyc(6);
        toggle_step(12);
        toggle_step(12);
        chk(ratio_a == 55 && ratio_b == 83 && ph_a_n && mon == 1, "R12", "hold then stride 8", ratio_a, 55);

        // R11 home and clear
        @(negedge clk); home = 1;
        wait_cyc(2); home = 0;
        wait_cyc(8);
        chk(ratio_a == 100 && ratio_b == 0 && mon == 0, "R11", "home to origin", ratio_a, 100);
        toggle_step(12);
        toggle_step(12);
        chk(ratio_a == 71, "R11", "moved before clear", ratio_a, 71);
        @(negedge clk); clr_n = 0;
        wait_cyc(2); clr_n = 1;
        wait_cyc(8);
        chk(ratio_a == 100 && ratio_b == 0, "R11", "clear to origin", ratio_a, 100);

        // sweep all modes and directions against the model (R4, R5)
        for (int m = 0; m < 8; m++) begin
            @(negedge clk);
            mode_sel = m[2:0];
            dir_fwd  = (m % 3 != 0);
            en_n     = (m == 5);
            wait_cyc(4);
            for (int i = 0; i < 9; i++) begin
                toggle_step(2 + (i % 4) * 3);
                if (i == 4) begin
                    @(negedge clk); step_clk = ~step_clk;
                    @(negedge clk); step_clk = ~step_clk;
                end
            end
            wait_cyc(10);
        end
        en_n = 0;
        wait_cyc(10);
        report();
    end

endmodule